// File: doc/BRIEF.md
# Four-beat wide search command assembler

This block listens to a host command bus and rebuilds a 288-bit search request that the host sends as four consecutive beats, named A, B, C and D. Each beat carries 72 bits of key data on the data bus, and the 11-bit command field changes meaning from beat to beat. The first and third beats each name a pair of global mask registers. The third beat also gives the upper bits of the result address. The fourth beat names the result register that will record the outcome.

A width flag in the command field tells the opening beat A apart from beat C, so the block follows the beat order with a small sequencer. A sequence that breaks off before beat D is discarded, and no partial request ever reaches the outputs. A complete sequence produces a one-cycle request pulse together with the assembled key and fields. These outputs then hold their values until the next complete request, even while a later sequence is being collected.

Top module: `wsrch_asm`

## Requirements
- R1: While reset is asserted and after its release, req_valid is 0 and srch_key, mask_idx_hi, mask_idx_lo, res_addr_hi and res_reg_idx are all zero until the first complete request.
- R2: Beat A is accepted only when cmd_valid is 1, cmd[1:0] equals 2'b10 (search) and cmd[2] is 1 (wide flag). Any other cycle leaves the block waiting for beat A.
- R3: The key is assembled in this order: beat A data goes to srch_key[287:216], beat B to [215:144], beat C to [143:72] and beat D to [71:0].
- R4: mask_idx_hi equals {cmd[10], cmd[5:3]} taken in beat A. mask_idx_lo equals {cmd[10], cmd[5:3]} taken in beat C.
- R5: res_addr_hi equals cmd[8:6] taken in beat C. res_reg_idx equals cmd[8:6] taken in beat D.
- R6: These bits have no effect on any output: cmd[9:6] in beat A, cmd[10:2] in beat B, and cmd[10:9] and cmd[5:2] in beat D.
- R7: In the slots for beats B, C or D, a cycle with cmd_valid at 0 or with cmd[1:0] not equal to 2'b10 discards the partial command. No request is issued and the block waits for a new beat A.
- R8: Beat C requires cmd[2] = 0. A search cycle with cmd[2] = 1 in the beat C slot discards the partial command and is itself taken as a new beat A.
- R9: req_valid is 1 for exactly one cycle, in the cycle after the clock edge that captures beat D.
- R10: All request outputs keep their values between requests, including while a later sequence is collected or discarded.
- R11: A beat A presented in the cycle directly after beat D is accepted. It leads to a correct second request and does not disturb the first request's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command beat strobe |
| cmd | input | 11 | Command field of the current beat |
| cmd_data | input | DATA_W (72) | Key data of the current beat |
| srch_key | output | 4*DATA_W (288) | Assembled search key |
| mask_idx_hi | output | 4 | Mask pair index for key bits [287:144] |
| mask_idx_lo | output | 4 | Mask pair index for key bits [143:0] |
| res_addr_hi | output | 3 | Result address bits [23:21] |
| res_reg_idx | output | 3 | Result register index |
| req_valid | output | 1 | One-cycle request pulse |

## Verification
Two things can happen in the same cycle: a finished request is issued, and the next command's beat A is captured. The bench provokes this by sending two commands with no idle cycle between them. In the overlap cycle it checks that req_valid is high with the first command's key and fields. In the cycle after, it checks that those outputs are still unchanged while the second sequence fills its staging storage. Finally, the second request must carry only the second command's data and fields.

// File: rtl/wsrch_pkg.sv
package wsrch_pkg;
    localparam int BEATS      = 4;
    localparam int CMD_W      = 11;
    localparam logic [1:0] OPC_SEARCH = 2'b10;
    localparam int WIDE_BIT   = 2;
    localparam int IDX_TOP    = 10;
    localparam int IDX_LO_LSB = 3;
    localparam int IDX_LO_W   = 3;
    localparam int MIDX_W     = IDX_LO_W + 1;
    localparam int FLD_LSB    = 6;
    localparam int FLD_W      = 3;

    // beat slot the sequencer is waiting for
    typedef enum logic [1:0] {
        ST_A = 2'd0,
        ST_B = 2'd1,
        ST_C = 2'd2,
        ST_D = 2'd3
    } seq_st_e;

    // fields of one command beat after decoding
    typedef struct packed {
        logic              ok;    // strobe high and search opcode
        logic              wide;  // width flag
        logic [MIDX_W-1:0] midx;  // mask pair index
        logic [FLD_W-1:0]  fld;   // address / result register field
    } beat_t;
endpackage

// File: rtl/wsrch_beat_dec.sv
module wsrch_beat_dec
    import wsrch_pkg::*;
(
    input  logic             valid_i,
    input  logic [CMD_W-1:0] cmd_i,
    output beat_t            beat_o
);
    always_comb begin
        beat_o.ok   = valid_i && (cmd_i[1:0] == OPC_SEARCH);
        beat_o.wide = cmd_i[WIDE_BIT];
        beat_o.midx = {cmd_i[IDX_TOP], cmd_i[IDX_LO_LSB +: IDX_LO_W]};
        beat_o.fld  = cmd_i[FLD_LSB +: FLD_W];
    end
endmodule

// File: rtl/wsrch_seq.sv
module wsrch_seq
    import wsrch_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  beat_t            beat_i,
    output logic [BEATS-1:0] cap_o,
    output seq_st_e          st_o
);
    typedef struct packed {
        seq_st_e st;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        cap_o = '0;
        unique case (s_q.st)
            ST_A: begin
                if (beat_i.ok && beat_i.wide) begin
                    cap_o[0] = 1'b1;
                    s_d.st   = ST_B;
                end
            end
            ST_B: begin
                if (beat_i.ok) begin
                    cap_o[1] = 1'b1;
                    s_d.st   = ST_C;
                end else begin
                    s_d.st   = ST_A;
                end
            end
            ST_C: begin
                if (beat_i.ok && !beat_i.wide) begin
                    cap_o[2] = 1'b1;
                    s_d.st   = ST_D;
                end else if (beat_i.ok) begin
                    // wide flag in the C slot: restart as a new beat A
                    cap_o[0] = 1'b1;
                    s_d.st   = ST_B;
                end else begin
                    s_d.st   = ST_A;
                end
            end
            ST_D: begin
                cap_o[BEATS-1] = beat_i.ok;
                s_d.st         = ST_A;
            end
            default: s_d.st = ST_A;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: ST_A};
        else        s_q <= s_d;
    end

    assign st_o = s_q.st;
endmodule

// File: rtl/wsrch_collect.sv
module wsrch_collect
    import wsrch_pkg::*;
#(
    parameter int DATA_W = 72
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [BEATS-1:0]        cap_i,
    input  beat_t                   beat_i,
    input  logic [DATA_W-1:0]       data_i,
    output logic [DATA_W*BEATS-1:0] key_o,
    output logic [MIDX_W-1:0]       midx_hi_o,
    output logic [MIDX_W-1:0]       midx_lo_o,
    output logic [FLD_W-1:0]        addr_hi_o,
    output logic [FLD_W-1:0]        rreg_o,
    output logic                    req_o
);
    localparam int KEY_W = DATA_W * BEATS;

    typedef struct packed {
        logic [KEY_W-1:0]  stg_key;
        logic [MIDX_W-1:0] stg_mhi;
        logic [MIDX_W-1:0] stg_mlo;
        logic [FLD_W-1:0]  stg_addr;
        logic [KEY_W-1:0]  key;
        logic [MIDX_W-1:0] mhi;
        logic [MIDX_W-1:0] mlo;
        logic [FLD_W-1:0]  addr;
        logic [FLD_W-1:0]  rreg;
        logic              req;
    } col_t;

    col_t c_d, c_q;
    logic [KEY_W-1:0] stg_nx;

    // beat g fills the g-th slice from the top of the key
    for (genvar g = 0; g < BEATS; g++) begin : g_slice
        localparam int HI = KEY_W - 1 - g * DATA_W;
        assign stg_nx[HI -: DATA_W] = cap_i[g] ? data_i : c_q.stg_key[HI -: DATA_W];
    end

    always_comb begin
        c_d         = c_q;
        c_d.req     = 1'b0;
        c_d.stg_key = stg_nx;
        if (cap_i[0]) c_d.stg_mhi = beat_i.midx;
        if (cap_i[2]) begin
            c_d.stg_mlo  = beat_i.midx;
            c_d.stg_addr = beat_i.fld;
        end
        if (cap_i[BEATS-1]) begin
            c_d.key  = stg_nx;
            c_d.mhi  = c_q.stg_mhi;
            c_d.mlo  = c_q.stg_mlo;
            c_d.addr = c_q.stg_addr;
            c_d.rreg = beat_i.fld;
            c_d.req  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign key_o     = c_q.key;
    assign midx_hi_o = c_q.mhi;
    assign midx_lo_o = c_q.mlo;
    assign addr_hi_o = c_q.addr;
    assign rreg_o    = c_q.rreg;
    assign req_o     = c_q.req;
endmodule

// File: rtl/wsrch_asm.sv
module wsrch_asm
    import wsrch_pkg::*;
#(
    parameter int DATA_W = 72
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    input  logic [CMD_W-1:0]        cmd,
    input  logic [DATA_W-1:0]       cmd_data,
    output logic [DATA_W*BEATS-1:0] srch_key,
    output logic [MIDX_W-1:0]       mask_idx_hi,
    output logic [MIDX_W-1:0]       mask_idx_lo,
    output logic [FLD_W-1:0]        res_addr_hi,
    output logic [FLD_W-1:0]        res_reg_idx,
    output logic                    req_valid
);
    beat_t            beat;
    logic [BEATS-1:0] cap;
    seq_st_e          seq_st;

    wsrch_beat_dec u_dec (
        .valid_i (cmd_valid),
        .cmd_i   (cmd),
        .beat_o  (beat)
    );

    wsrch_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .beat_i (beat),
        .cap_o  (cap),
        .st_o   (seq_st)
    );

    wsrch_collect #(.DATA_W(DATA_W)) u_col (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_i     (cap),
        .beat_i    (beat),
        .data_i    (cmd_data),
        .key_o     (srch_key),
        .midx_hi_o (mask_idx_hi),
        .midx_lo_o (mask_idx_lo),
        .addr_hi_o (res_addr_hi),
        .rreg_o    (res_reg_idx),
        .req_o     (req_valid)
    );
endmodule

// File: rtl/wsrch_asm_chk.sv
module wsrch_asm_chk
    import wsrch_pkg::*;
#(
    parameter int DATA_W = 72
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cmd_valid,
    input logic [CMD_W-1:0]        cmd,
    input logic [DATA_W-1:0]       cmd_data,
    input logic [DATA_W*BEATS-1:0] srch_key,
    input logic [MIDX_W-1:0]       mask_idx_hi,
    input logic [MIDX_W-1:0]       mask_idx_lo,
    input logic [FLD_W-1:0]        res_addr_hi,
    input logic [FLD_W-1:0]        res_reg_idx,
    input logic                    req_valid,
    input seq_st_e                 st
);
    logic srch_beat;
    assign srch_beat = cmd_valid && (cmd[1:0] == OPC_SEARCH);

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    a_r9_after_beat_d: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ($past(st) == ST_D) && $past(srch_beat));

    a_r3_last_slice: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> srch_key[DATA_W-1:0] == $past(cmd_data));

    a_r5_result_reg: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> res_reg_idx == $past(cmd[FLD_LSB +: FLD_W]));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> $stable(srch_key) && $stable(mask_idx_hi) && $stable(mask_idx_lo)
                       && $stable(res_addr_hi) && $stable(res_reg_idx));

    a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_A) && !srch_beat |=> st == ST_A);

    a_r2_wait_a: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_A) && !(srch_beat && cmd[WIDE_BIT]) |=> st == ST_A);

    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_C) && srch_beat && cmd[WIDE_BIT] |=> st == ST_B);
endmodule

bind wsrch_asm wsrch_asm_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd         (cmd),
    .cmd_data    (cmd_data),
    .srch_key    (srch_key),
    .mask_idx_hi (mask_idx_hi),
    .mask_idx_lo (mask_idx_lo),
    .res_addr_hi (res_addr_hi),
    .res_reg_idx (res_reg_idx),
    .req_valid   (req_valid),
    .st          (seq_st)
);

// File: tb/test_wsrch_asm.sv
`timescale 1ns/1ps
module test_wsrch_asm;
    localparam int DW = 72;
    localparam int KW = DW * 4;
    localparam int NV = 8;

    // v/op: bit i refers to beat i; op bit 1 -> cmd[1:0]=2'b10, else 2'b11
    typedef struct packed {
        logic [3:0] v;
        logic [3:0] op;
        logic       wide;
        logic [7:0] seed;
        logic       ok;
    } vec_t;

    localparam vec_t VT [NV] = '{
        '{4'b1111, 4'b1111, 1'b1, 8'h11, 1'b1},  // R3 R4 R5 good
        '{4'b1111, 4'b1111, 1'b1, 8'h5A, 1'b1},  // good, new fields
        '{4'b1111, 4'b1111, 1'b0, 8'h23, 1'b0},  // R2 narrow A
        '{4'b1101, 4'b1111, 1'b1, 8'h34, 1'b0},  // R7 strobe low in B
        '{4'b1111, 4'b1011, 1'b1, 8'h45, 1'b0},  // R7 bad opcode in C
        '{4'b0111, 4'b1111, 1'b1, 8'h56, 1'b0},  // R7 strobe low in D
        '{4'b1110, 4'b1111, 1'b1, 8'h67, 1'b0},  // R2 A strobe low
        '{4'b1111, 4'b1111, 1'b1, 8'hC3, 1'b1}   // good after aborts
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [10:0]   cmd = '0;
    logic [DW-1:0] cmd_data = '0;
    logic [KW-1:0] srch_key;
    logic [3:0]    mask_idx_hi, mask_idx_lo;
    logic [2:0]    res_addr_hi, res_reg_idx;
    logic          req_valid;

    int n_chk = 0;
    int n_fail = 0;

    logic [KW-1:0] e_key = '0;
    logic [3:0]    e_mhi = '0, e_mlo = '0;
    logic [2:0]    e_addr = '0, e_rreg = '0;

    always #2 clk = ~clk;

    wsrch_asm #(.DATA_W(DW)) i_wsrch_asm (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd), .cmd_data(cmd_data),
        .srch_key(srch_key), .mask_idx_hi(mask_idx_hi), .mask_idx_lo(mask_idx_lo),
        .res_addr_hi(res_addr_hi), .res_reg_idx(res_reg_idx), .req_valid(req_valid)
    );

    function automatic logic [10:0] mkcmd(logic [7:0] seed, int beat, logic opok, logic w);
        logic [7:0] up;
        up = 8'(int'(seed) * (beat + 3) + beat * 41);
        return {up, w, (opok ? 2'b10 : 2'b11)};
    endfunction

    function automatic logic [DW-1:0] mkdata(logic [7:0] seed, int beat);
        return {seed, 8'(beat), 56'(int'(seed) * 1000003 + beat * 77777)};
    endfunction

    task automatic chk(input string tag, input logic [KW-1:0] act, input logic [KW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic beat(input logic v, input logic [10:0] c, input logic [DW-1:0] d);
        @(negedge clk);
        cmd_valid = v; cmd = c; cmd_data = d;
    endtask

    task automatic idle();
        @(negedge clk);
        cmd_valid = 1'b0; cmd = '0; cmd_data = '0;
    endtask

    // expected request fields from four beats, per R3 R4 R5
    task automatic set_exp(input logic [10:0] c0, input logic [10:0] c2, input logic [10:0] c3,
                           input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                           input logic [DW-1:0] d2, input logic [DW-1:0] d3);
        e_key  = {d0, d1, d2, d3};
        e_mhi  = {c0[10], c0[5:3]};
        e_mlo  = {c2[10], c2[5:3]};
        e_addr = c2[8:6];
        e_rreg = c3[8:6];
    endtask

    task automatic chk_outs(input string tag);
        chk({tag, " R3 key"}, srch_key, e_key);
        chk({tag, " R4 mask_idx_hi"}, KW'(mask_idx_hi), KW'(e_mhi));
        chk({tag, " R4 mask_idx_lo"}, KW'(mask_idx_lo), KW'(e_mlo));
        chk({tag, " R5 res_addr_hi"}, KW'(res_addr_hi), KW'(e_addr));
        chk({tag, " R5 res_reg_idx"}, KW'(res_reg_idx), KW'(e_rreg));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [10:0]   c [4];
        logic [DW-1:0] d [4];
        logic [10:0]   c_b [4];

        repeat (3) @(negedge clk);
        chk("R1 req_valid in reset", KW'(req_valid), '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 req_valid after reset", KW'(req_valid), '0);
        chk_outs("R1 reset");

        // table walk
        for (int i = 0; i < NV; i++) begin
            for (int b = 0; b < 4; b++) begin
                c[b] = mkcmd(VT[i].seed, b, VT[i].op[b], (b == 0) ? VT[i].wide : 1'b0);
                d[b] = mkdata(VT[i].seed, b);
                beat(VT[i].v[b], c[b], d[b]);
            end
            idle();
            chk($sformatf("R9 R7 R2 vec%0d request", i), KW'(req_valid), KW'(VT[i].ok));
            if (VT[i].ok) set_exp(c[0], c[2], c[3], d[0], d[1], d[2], d[3]);
            chk_outs($sformatf("vec%0d", i));
            idle();
            chk($sformatf("R9 vec%0d single pulse", i), KW'(req_valid), '0);
            chk($sformatf("R10 vec%0d hold key", i), srch_key, e_key);
        end

        // R6: ignored command bits set, same result as base command
        for (int b = 0; b < 4; b++) begin
            c[b] = mkcmd(8'h7E, b, 1'b1, b == 0);
            d[b] = mkdata(8'h7E, b);
        end
        c_b[0] = c[0] ^ 11'b010_0100_0000 ^ 11'b001_1000_0000; // flip cmd[9:6]
        c_b[1] = c[1] | 11'b111_1111_1100;                    // cmd[10:2]
        c_b[2] = c[2];
        c_b[3] = c[3] ^ 11'b110_0011_1100;                    // cmd[10:9], cmd[5:2]
        for (int b = 0; b < 4; b++) beat(1'b1, c_b[b], d[b]);
        idle();
        chk("R6 request with ignored bits", KW'(req_valid), 1);
        set_exp(c[0], c[2], c[3], d[0], d[1], d[2], d[3]);
        chk_outs("R6 ignored bits");

        // R8: wide flag in the C slot restarts as a new beat A
        beat(1'b1, mkcmd(8'h90, 0, 1'b1, 1'b1), mkdata(8'h90, 0));
        beat(1'b1, mkcmd(8'h90, 1, 1'b1, 1'b0), mkdata(8'h90, 1));
        for (int b = 0; b < 4; b++) begin
            c[b] = mkcmd(8'hA5, b, 1'b1, b == 0);
            d[b] = mkdata(8'hA5, b);
            beat(1'b1, c[b], d[b]);
            if (b == 1) chk("R8 no request during restart", KW'(req_valid), '0);
        end
        idle();
        chk("R8 request after restart", KW'(req_valid), 1);
        set_exp(c[0], c[2], c[3], d[0], d[1], d[2], d[3]);
        chk_outs("R8 restart");
        idle();

        // R11: back-to-back commands
        for (int b = 0; b < 4; b++) begin
            c[b] = mkcmd(8'h3C, b, 1'b1, b == 0);
            d[b] = mkdata(8'h3C, b);
            beat(1'b1, c[b], d[b]);
        end
        set_exp(c[0], c[2], c[3], d[0], d[1], d[2], d[3]);
        for (int b = 0; b < 4; b++) begin
            c_b[b] = mkcmd(8'hE1, b, 1'b1, b == 0);
            beat(1'b1, c_b[b], mkdata(8'hE1, b));
            if (b == 0) begin
                chk("R11 first request during next beat A", KW'(req_valid), 1);
                chk_outs("R11 first");
            end
            if (b == 1) begin
                chk("R9 R11 pulse ended", KW'(req_valid), '0);
                chk_outs("R10 R11 hold during second");
            end
        end
        idle();
        chk("R11 second request", KW'(req_valid), 1);
        set_exp(c_b[0], c_b[2], c_b[3], mkdata(8'hE1, 0), mkdata(8'hE1, 1),
                mkdata(8'hE1, 2), mkdata(8'hE1, 3));
        chk_outs("R11 second");
        idle();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule